// File: doc/BRIEF.md
# Write-and-Poll Bus Master for Parallel Non-Volatile Memory

This block sits on the host side of an asynchronous byte-wide non-volatile memory. It accepts one request from a client, performs one or more byte loads within a single page, and then finds out when the memory's internal programming has ended. It does this with ordinary read cycles, not a ready pin or a fixed worst-case wait. It drives the chip-select, read-strobe and write-strobe lines (all active low), the address and the write data. Every bus phase lasts a whole number of clock cycles, and each duration is a parameter.

Two ways of detecting completion can be chosen for each request. In the first, the block keeps the last address and data it wrote, rereads that address, and stops once the top data bit matches the written value. In the second, the block rereads the device and stops once the next-to-top bit gives the same value on two reads in a row. A polling window that is too long ends the request with an error. The client presents the first byte with the request. After each load that is not the last, the block sends a one-cycle pulse, and the client then presents the next byte.

Top module: `nvm_write_poller`

## Requirements
- R1: While reset is held and just after it, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are high, and `mem_dq_oe`, `cl_busy`, `cl_done` and `cl_err` are low.
- R2: `cl_req` is acted on only while `cl_busy` is low. A request raised while busy causes no bus cycle and does not change the transaction in progress.
- R3: During a byte load, `mem_ce_n` and `mem_we_n` are low, `mem_oe_n` is high and `mem_dq_oe` is high, for exactly WE_LOW_CYC cycles. Between loads all three strobes stay high for WE_HIGH_CYC cycles, which must be at least 2.
- R4: A request writes `cl_len_m1`+1 bytes. Byte k goes to an address whose bits above PAGE_AW come from `cl_addr`, and whose low PAGE_AW bits are (`cl_addr` low bits + k) modulo 2^PAGE_AW. Byte 0 is `cl_data` at the request. Byte k>0 is `cl_data` after the k-th one-cycle `cl_adv` pulse, and one pulse follows each load except the last.
- R5: At least POLL_GAP_CYC cycles pass between `mem_we_n` rising after the final load and the first fall of `mem_oe_n`.
- R6: A polling read holds `mem_ce_n` and `mem_oe_n` low and `mem_we_n` high for exactly RD_ACC_CYC cycles, at the last written address. `mem_dq_in` is taken in the last of those cycles. Consecutive reads are separated by RD_GAP_CYC cycles with all strobes high.
- R7: With `cl_mode`=0, the request completes at the first read whose bit DATA_W-1 equals bit DATA_W-1 of the last byte written.
- R8: With `cl_mode`=1, the request completes at the first read whose bit DATA_W-2 equals the same bit of the read just before it. The first read of a request never completes it.
- R9: Count cycles from the first cycle after the final `mem_we_n` rise (that cycle is count 0). A read that does not complete and whose sampling cycle has a count of at least TIMEOUT_CYC ends the request with `cl_err`=1. No error is given earlier.
- R10: The end of a request is a one-cycle `cl_done` pulse. It appears in the cycle in which `mem_oe_n` returns high after the deciding read, with `cl_busy` low. When a read both completes the request and reaches the timeout, completion wins and `cl_err` is 0. `cl_err` holds its value until the next accepted request.
- R11: `mem_dq_oe` is never high while `mem_oe_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cl_req | input | 1 | Start a write-and-poll transaction |
| cl_mode | input | 1 | 0: top-bit compare, 1: alternating-bit compare |
| cl_addr | input | ADDR_W | Address of the first byte |
| cl_len_m1 | input | PAGE_AW | Number of bytes minus one |
| cl_data | input | DATA_W | Byte to be loaded next |
| cl_adv | output | 1 | One-cycle pulse: present the next byte |
| cl_busy | output | 1 | Transaction in progress |
| cl_done | output | 1 | One-cycle end-of-transaction pulse |
| cl_err | output | 1 | Transaction ended by timeout |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | DATA_W | Write data |
| mem_dq_oe | output | 1 | Drive enable for write data |
| mem_dq_in | input | DATA_W | Read data from the memory |

## Verification
Detecting completion and expiring the timeout are both decided in the sampling cycle of one read, so they can coincide. To provoke this, the device model's busy time is swept in single-cycle steps over a range that straddles the timeout and is wider than one read period, so some read both reaches the limit and sees the finished value. At every read end the bench works out from its own record of the sampled byte and the cycles since the final write which outcome is due. A matching read must give a clean finish even past the limit, and an error is accepted only when no read matched.

// File: rtl/nvm_poll_pkg.sv
package nvm_poll_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_WLO    = 3'd1,
        ST_WHI    = 3'd2,
        ST_SETTLE = 3'd3,
        ST_RD     = 3'd4,
        ST_RGAP   = 3'd5
    } poll_state_e;

    typedef enum logic {
        MODE_DATA   = 1'b0,
        MODE_TOGGLE = 1'b1
    } poll_mode_e;

    function automatic int max_u(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/poll_phase_timer.sv
// Down-counter that sets how long each bus phase lasts.
module poll_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/poll_elapsed_ctr.sv
// Saturating count of the cycles spent polling.
module poll_elapsed_ctr #(
    parameter int W     = 20,
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic reached
);
    logic [W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (clr) begin
            count_d = '0;
        end else if (en && (count_q < W'(LIMIT))) begin
            count_d = count_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign reached = (count_q >= W'(LIMIT));
endmodule

// File: rtl/poll_status_judge.sv
// Decides whether one polling read shows that programming has ended.
module poll_status_judge #(
    parameter int DATA_W = 8
) (
    input  logic              toggle_mode,
    input  logic [DATA_W-1:0] rd_byte,
    input  logic              saved_msb,
    input  logic              have_prev,
    input  logic              prev_tb,
    output logic              match,
    output logic              tb_now
);
    localparam int DP_BIT = DATA_W - 1;
    localparam int TB_BIT = DATA_W - 2;

    logic unused_low;
    assign unused_low = ^rd_byte[TB_BIT-1:0];

    assign tb_now = rd_byte[TB_BIT];

    always_comb begin
        if (toggle_mode) begin
            match = have_prev && (rd_byte[TB_BIT] == prev_tb);
        end else begin
            match = (rd_byte[DP_BIT] == saved_msb);
        end
    end
endmodule

// File: rtl/nvm_write_poller.sv
module nvm_write_poller
    import nvm_poll_pkg::*;
#(
    parameter int ADDR_W       = 13,
    parameter int DATA_W       = 8,
    parameter int PAGE_AW      = 6,
    parameter int WE_LOW_CYC   = 7,
    parameter int WE_HIGH_CYC  = 7,
    parameter int RD_ACC_CYC   = 9,
    parameter int RD_GAP_CYC   = 4,
    parameter int POLL_GAP_CYC = 1250,
    parameter int TIMEOUT_CYC  = 625000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cl_req,
    input  logic               cl_mode,
    input  logic [ADDR_W-1:0]  cl_addr,
    input  logic [PAGE_AW-1:0] cl_len_m1,
    input  logic [DATA_W-1:0]  cl_data,
    output logic               cl_adv,
    output logic               cl_busy,
    output logic               cl_done,
    output logic               cl_err,
    output logic               mem_ce_n,
    output logic               mem_oe_n,
    output logic               mem_we_n,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_dq_out,
    output logic               mem_dq_oe,
    input  logic [DATA_W-1:0]  mem_dq_in
);
    localparam int PH_MAX = max_u(max_u(WE_LOW_CYC, WE_HIGH_CYC),
                                  max_u(max_u(RD_ACC_CYC, RD_GAP_CYC), POLL_GAP_CYC));
    localparam int TW     = $clog2(PH_MAX + 1);
    localparam int EW     = $clog2(TIMEOUT_CYC + 1);
    localparam int DP_BIT = DATA_W - 1;

    localparam logic [TW-1:0] LD_WLO    = TW'(WE_LOW_CYC - 1);
    localparam logic [TW-1:0] LD_WHI    = TW'(WE_HIGH_CYC - 1);
    localparam logic [TW-1:0] LD_RD     = TW'(RD_ACC_CYC - 1);
    localparam logic [TW-1:0] LD_RGAP   = TW'(RD_GAP_CYC - 1);
    localparam logic [TW-1:0] LD_SETTLE = TW'(POLL_GAP_CYC - 1);

    typedef struct packed {
        poll_state_e        st;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  data;
        logic [PAGE_AW-1:0] left;
        poll_mode_e         mode;
        logic               have_prev;
        logic               prev_tb;
        logic               adv;
        logic               done;
        logic               err;
    } regs_t;

    regs_t r_d, r_q;

    logic          tm_load;
    logic [TW-1:0] tm_val;
    logic          tm_zero;
    logic          el_clr;
    logic          el_en;
    logic          el_reached;
    logic          st_match;
    logic          st_tb;

    poll_phase_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tm_load),
        .load_val (tm_val),
        .zero     (tm_zero)
    );

    poll_elapsed_ctr #(.W(EW), .LIMIT(TIMEOUT_CYC)) u_elapsed (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (el_clr),
        .en      (el_en),
        .reached (el_reached)
    );

    poll_status_judge #(.DATA_W(DATA_W)) u_judge (
        .toggle_mode (r_q.mode == MODE_TOGGLE),
        .rd_byte     (mem_dq_in),
        .saved_msb   (r_q.data[DP_BIT]),
        .have_prev   (r_q.have_prev),
        .prev_tb     (r_q.prev_tb),
        .match       (st_match),
        .tb_now      (st_tb)
    );

    assign el_en = (r_q.st == ST_SETTLE) || (r_q.st == ST_RD) || (r_q.st == ST_RGAP);

    always_comb begin
        r_d      = r_q;
        r_d.adv  = 1'b0;
        r_d.done = 1'b0;
        tm_load  = 1'b0;
        tm_val   = '0;
        el_clr   = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (cl_req) begin
                    r_d.addr      = cl_addr;
                    r_d.data      = cl_data;
                    r_d.left      = cl_len_m1;
                    r_d.mode      = poll_mode_e'(cl_mode);
                    r_d.have_prev = 1'b0;
                    r_d.err       = 1'b0;
                    r_d.st        = ST_WLO;
                    tm_load       = 1'b1;
                    tm_val        = LD_WLO;
                end
            end
            ST_WLO: begin
                if (tm_zero) begin
                    if (r_q.left == '0) begin
                        r_d.st  = ST_SETTLE;
                        tm_load = 1'b1;
                        tm_val  = LD_SETTLE;
                        el_clr  = 1'b1;
                    end else begin
                        r_d.st                 = ST_WHI;
                        r_d.left               = r_q.left - 1'b1;
                        r_d.addr[PAGE_AW-1:0]  = r_q.addr[PAGE_AW-1:0] + 1'b1;
                        r_d.adv                = 1'b1;
                        tm_load                = 1'b1;
                        tm_val                 = LD_WHI;
                    end
                end
            end
            ST_WHI: begin
                if (tm_zero) begin
                    r_d.data = cl_data;
                    r_d.st   = ST_WLO;
                    tm_load  = 1'b1;
                    tm_val   = LD_WLO;
                end
            end
            ST_SETTLE: begin
                if (tm_zero) begin
                    r_d.st  = ST_RD;
                    tm_load = 1'b1;
                    tm_val  = LD_RD;
                end
            end
            ST_RD: begin
                if (tm_zero) begin
                    r_d.have_prev = 1'b1;
                    r_d.prev_tb   = st_tb;
                    if (st_match) begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                        r_d.err  = 1'b0;
                    end else if (el_reached) begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                        r_d.err  = 1'b1;
                    end else begin
                        r_d.st  = ST_RGAP;
                        tm_load = 1'b1;
                        tm_val  = LD_RGAP;
                    end
                end
            end
            ST_RGAP: begin
                if (tm_zero) begin
                    r_d.st  = ST_RD;
                    tm_load = 1'b1;
                    tm_val  = LD_RD;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, addr: '0, data: '0, left: '0, mode: MODE_DATA,
                     have_prev: 1'b0, prev_tb: 1'b0, adv: 1'b0, done: 1'b0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_ce_n   = !((r_q.st == ST_WLO) || (r_q.st == ST_RD));
    assign mem_we_n   = (r_q.st != ST_WLO);
    assign mem_oe_n   = (r_q.st != ST_RD);
    assign mem_dq_oe  = (r_q.st == ST_WLO);
    assign mem_addr   = r_q.addr;
    assign mem_dq_out = r_q.data;
    assign cl_busy    = (r_q.st != ST_IDLE);
    assign cl_done    = r_q.done;
    assign cl_err     = r_q.err;
    assign cl_adv     = r_q.adv;
endmodule

// File: rtl/nvm_write_poller_chk.sv
module nvm_write_poller_chk #(
    parameter int WE_LOW_CYC   = 7,
    parameter int RD_ACC_CYC   = 9,
    parameter int POLL_GAP_CYC = 1250
) (
    input logic clk,
    input logic rst_n,
    input logic mem_ce_n,
    input logic mem_oe_n,
    input logic mem_we_n,
    input logic mem_dq_oe,
    input logic cl_done,
    input logic cl_busy
);
    logic [31:0] we_run, oe_run, gap_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_run  <= '0;
            oe_run  <= '0;
            gap_run <= '0;
        end else begin
            we_run  <= mem_we_n ? '0 : we_run + 1'b1;
            oe_run  <= mem_oe_n ? '0 : oe_run + 1'b1;
            if (!mem_we_n) begin
                gap_run <= '0;
            end else if (gap_run != '1) begin
                gap_run <= gap_run + 1'b1;
            end
        end
    end

    assert_write_strobes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));

    assert_we_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_run >= 32'(WE_LOW_CYC)));

    assert_poll_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> (gap_run >= 32'(POLL_GAP_CYC)));

    assert_read_strobes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_ce_n));

    assert_read_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (oe_run >= 32'(RD_ACC_CYC)));

    assert_no_contention_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cl_done |=> !cl_done);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cl_done |-> !cl_busy);
endmodule

bind nvm_write_poller nvm_write_poller_chk #(
    .WE_LOW_CYC   (WE_LOW_CYC),
    .RD_ACC_CYC   (RD_ACC_CYC),
    .POLL_GAP_CYC (POLL_GAP_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe),
    .cl_done   (cl_done),
    .cl_busy   (cl_busy)
);

// File: tb/nvm_write_poller_test.sv
module nvm_write_poller_test;
    localparam int AW = 13, DW = 8, PW = 6;
    localparam int WLO = 3, WHI = 2, RACC = 4, RGAP = 2, PGAP = 10, TMO = 300;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cl_req = 1'b0;
    logic          cl_mode = 1'b0;
    logic [AW-1:0] cl_addr = '0;
    logic [PW-1:0] cl_len_m1 = '0;
    logic [DW-1:0] cl_data = '0;
    logic          cl_adv, cl_busy, cl_done, cl_err;
    logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in = 8'h5a;

    always #4 clk = ~clk;

    nvm_write_poller #(
        .ADDR_W(AW), .DATA_W(DW), .PAGE_AW(PW), .WE_LOW_CYC(WLO), .WE_HIGH_CYC(WHI),
        .RD_ACC_CYC(RACC), .RD_GAP_CYC(RGAP), .POLL_GAP_CYC(PGAP), .TIMEOUT_CYC(TMO)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cl_req(cl_req), .cl_mode(cl_mode), .cl_addr(cl_addr),
        .cl_len_m1(cl_len_m1), .cl_data(cl_data), .cl_adv(cl_adv), .cl_busy(cl_busy),
        .cl_done(cl_done), .cl_err(cl_err), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_val(input int seed, input int k);
        return 8'(seed * 13 + k * 29 + (k >> 2));
    endfunction

    // transaction description (written by the stimulus, read by the monitor)
    bit          tx_mode;
    logic [12:0] tx_addr;
    int          tx_busy, tx_seed;

    // monitor / device model state
    logic [7:0]  bmem [0:8191];
    int          wr_idx, adv_cnt, we_lo, oe_lo, since_we, busy_left;
    logic [12:0] cap_a, last_a;
    logic [7:0]  cap_d, last_d, pv;
    bit          prev_we = 1'b1, prev_oe = 1'b1, tog, first_rd, have_prev_b, prev_b6;
    bit          got_done, got_err, strobe_bad, cont_bad;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (cl_req && !cl_busy) begin
                wr_idx = 0; adv_cnt = 0; first_rd = 1; have_prev_b = 0;
                got_done = 0; strobe_bad = 0; cont_bad = 0;
            end
            if (cl_adv) adv_cnt++;
            cl_data = byte_val(tx_seed, adv_cnt);

            if (!mem_we_n) begin
                we_lo++;
                cap_a = mem_addr; cap_d = mem_dq_out;
                if (mem_ce_n || !mem_oe_n || !mem_dq_oe) strobe_bad = 1;
            end
            if (mem_we_n && !prev_we) begin
                logic [12:0] ea;
                ea = {tx_addr[12:6], 6'(tx_addr[5:0] + 6'(wr_idx))};
                chk(we_lo == WLO, "R3", "write strobe width", we_lo, WLO);
                chk(cap_a == ea, "R4", "load address", cap_a, ea);
                chk(cap_d == byte_val(tx_seed, wr_idx), "R4", "load data",
                    cap_d, byte_val(tx_seed, wr_idx));
                bmem[cap_a] = cap_d;
                last_a = cap_a; last_d = cap_d;
                busy_left = tx_busy; since_we = 0; wr_idx++; we_lo = 0;
            end else begin
                since_we++;
            end

            if (mem_dq_oe && !mem_oe_n) cont_bad = 1;
            if (!mem_oe_n) begin
                if (prev_oe) begin
                    tog = ~tog; oe_lo = 0;
                    if (first_rd) begin
                        chk(since_we >= PGAP, "R5", "gap before first read", since_we, PGAP);
                        first_rd = 0;
                    end
                    chk(mem_addr == last_a, "R6", "read address", mem_addr, last_a);
                end
                if (!mem_we_n || mem_ce_n) strobe_bad = 1;
                oe_lo++;
                pv = (busy_left > 0) ? {~last_d[7], tog, last_d[5:0]} : bmem[mem_addr];
                mem_dq_in = pv;
            end else begin
                mem_dq_in = 8'h5a;
            end

            if (mem_oe_n && !prev_oe) begin
                bit m, ed, ee, late;
                string tag;
                chk(oe_lo == RACC, "R6", "read strobe width", oe_lo, RACC);
                m = tx_mode ? (have_prev_b && (pv[6] == prev_b6)) : (pv[7] == last_d[7]);
                have_prev_b = 1; prev_b6 = pv[6];
                late = (since_we >= TMO + 1);
                ed = m || late;
                ee = !m && late;
                tag = (m && late) ? "R10" : (late ? "R9" : (tx_mode ? "R8" : "R7"));
                chk(cl_done == ed, tag, "done after read", cl_done, ed);
                if (ed && cl_done) chk(cl_err == ee, tag, "error flag", cl_err, ee);
                if (cl_done) begin got_done = 1; got_err = cl_err; end
            end

            if (busy_left > 0) busy_left--;
            prev_we = mem_we_n;
            prev_oe = mem_oe_n;
        end
    end

    task automatic run_tx(input bit mode, input logic [12:0] a, input int lenm1,
                          input int busy, input int seed, input bit inject);
        int w;
        @(posedge clk); #1;
        tx_mode = mode; tx_addr = a; tx_busy = busy; tx_seed = seed;
        cl_mode = mode; cl_addr = a; cl_len_m1 = PW'(lenm1); cl_req = 1'b1;
        @(posedge clk); #1;
        cl_req = 1'b0;
        if (inject) begin
            repeat (3) @(posedge clk);
            #1; cl_addr = a ^ 13'h1fc0; cl_mode = ~mode; cl_req = 1'b1;
            @(posedge clk); #1; cl_req = 1'b0; cl_addr = a; cl_mode = mode;
        end
        w = 0;
        while (!got_done && w < 20000) begin @(posedge clk); w++; end
        chk(got_done, "R10", "transaction ended", got_done, 1);
        repeat (4) @(negedge clk);
        chk(wr_idx == lenm1 + 1, inject ? "R2" : "R4", "bytes loaded", wr_idx, lenm1 + 1);
        chk(adv_cnt == lenm1, "R4", "advance pulses", adv_cnt, lenm1);
        chk(!cl_busy, "R2", "idle after done", cl_busy, 0);
        chk(cl_err == got_err, "R10", "error held", cl_err, got_err);
        chk(!strobe_bad, "R3", "strobe combination", strobe_bad, 0);
        chk(!cont_bad, "R11", "bus contention", cont_bad, 0);
    endtask

    initial begin
        int cnt;
        cnt = 0;
        while (cyc < 150000) begin @(posedge clk); cnt++; end
        chk(0, "R10", "watchdog expired", cyc, 150000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 8192; i++) bmem[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n, "R1", "strobes in reset",
            {mem_ce_n, mem_oe_n, mem_we_n}, 7);
        chk(!mem_dq_oe && !cl_busy && !cl_done && !cl_err, "R1", "flags in reset",
            {mem_dq_oe, cl_busy, cl_done, cl_err}, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n && !cl_busy, "R1", "state after reset",
            {mem_ce_n, mem_oe_n, mem_we_n, cl_busy}, 14);

        run_tx(1'b0, 13'h0123, 0, 30, 5, 1'b0);    // R7 single byte
        run_tx(1'b0, 13'h0456, 0, 30, 70, 1'b0);   // R7 other top-bit value
        run_tx(1'b1, 13'h0789, 0, 30, 9, 1'b0);    // R8 single byte
        run_tx(1'b0, 13'h1a7c, 63, 40, 11, 1'b0);  // R4 full page with wrap
        run_tx(1'b1, 13'h0440, 5, 40, 21, 1'b1);   // R2 request while busy
        run_tx(1'b0, 13'h0200, 2, 4000, 33, 1'b0); // R9 timeout, data mode
        run_tx(1'b1, 13'h0300, 1, 4000, 34, 1'b0); // R9 timeout, toggle mode
        for (int b = TMO - 12; b < TMO + PGAP + 12; b++) begin
            run_tx(1'b0, 13'h0500, 0, b, b, 1'b0);  // R10 boundary sweep
        end
        for (int k = 0; k < 25; k++) begin
            run_tx(1'($urandom_range(0, 1)), 13'($urandom), $urandom_range(0, 7),
                   $urandom_range(12, 220), $urandom_range(0, 255), 1'b0);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule